// File: doc/BRIEF.md
# SHA-256 Two-Round Compression Step

This block moves the SHA-256 working state forward by two compression rounds in one operation. The eight working words are carried in two 128-bit halves. One half holds A, B, E and F and the other holds C, D, G and H. A third 128-bit input supplies, in its low 64 bits, two sums that the caller has already computed. Each sum is one message-schedule word plus its round constant. The block returns only the new A, B, E and F half.

The new C, D, G and H half is not produced, because it is exactly the incoming A, B, E, F word. A caller therefore chains calls in a simple way. The previous A/B/E/F word becomes the next C/D/G/H word, and the block's result becomes the next A/B/E/F word. Thirty-two calls cover the full 64 rounds.

The two rounds are a purely combinational chain. A one-cycle `start` strobe captures the result into an output register, and `done` pulses for one cycle at the same time. Message expansion, round-constant storage, padding, the final digest addition and round sequencing all belong to the caller.

Top module: `sha2_dual_round`

## Requirements
- R1: While `rst_n` is low at a clock edge, `abef_out` becomes zero and `done` becomes low at that edge.
- R2: When `start` is high at a clock edge, `abef_out` holds the two-round result after that edge and `done` is high for exactly that one following cycle.
- R3: When `start` is low at a clock edge, `done` is low after that edge and `abef_out` keeps its value, even if the data inputs change.
- R4: Input words are taken by bit position. In `abef_in`, A is [127:96], B is [95:64], E is [63:32] and F is [31:0]. In `cdgh_in`, C is [127:96], D is [95:64], G is [63:32] and H is [31:0].
- R5: In each round, the new A is the sum modulo 2^32 of six terms: Ch(E,F,G), Σ1(E), the round's WK, H, Maj(A,B,C) and Σ0(A). Here Σ0 is the XOR of right rotations by 2, 13 and 22, and Σ1 is the XOR of right rotations by 6, 11 and 25.
- R6: In each round, the new E is the sum modulo 2^32 of Ch(E,F,G), Σ1(E), WK, H and D. The other words shift along: B, C and D take the old A, B and C, and F, G and H take the old E, F and G.
- R7: The first round uses `wk_in[31:0]` and the second round uses `wk_in[63:32]`. Bits [127:64] of `wk_in` have no effect on the result.
- R8: The result is packed as A2 in [127:96], B2 in [95:64], E2 in [63:32] and F2 in [31:0].
- R9: Chaining 32 calls, swapping the halves between calls as described above, performs 64 standard SHA-256 rounds. Starting from the standard initial hash on the padded "abc" block, it yields the digest minus the initial hash, word by word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture the two-round result at this edge |
| cdgh_in | input | 128 | Working words C, D, G, H |
| abef_in | input | 128 | Working words A, B, E, F |
| wk_in | input | 128 | Low 64 bits hold the two message-plus-constant sums |
| abef_out | output | 128 | Registered new A, B, E, F |
| done | output | 1 | One-cycle pulse after a start |

## Verification
The hardest behaviour to reach from the ports is the full 64-round run. A wrong rotation amount or a swapped word often survives one random call, but it cannot survive 32 chained calls that must land on a known digest. The bench builds the "abc" message schedule itself and adds the round constants. It then feeds the block's own results back, with the halves swapped, and compares the final eight words with the digest minus the initial hash. Random calls and all-zero and all-ones states add breadth, and a change to only the high bits of `wk_in` checks that those bits are ignored.

// File: rtl/sha2_dual_pkg.sv
`timescale 1ns/1ps
// Package: shared word width, working-state type and the SHA-256 round
// functions. Assumes 32-bit words, which the rotation amounts require.
package sha2_dual_pkg;
    localparam int WORD_W  = 32;
    localparam int LANES   = 4;
    localparam int BUS_W   = LANES * WORD_W;
    localparam int ROUNDS  = 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } wstate_t;

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t f_choose(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (~x & z);
    endfunction

    function automatic word_t f_major(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (x & z) ^ (y & z);
    endfunction

    function automatic word_t f_bsig0(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t f_bsig1(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction
endpackage

// File: rtl/sha2_round_step.sv
`timescale 1ns/1ps
// Module: one SHA-256 compression round, purely combinational.
// Assumes wk is the message word already added to its round constant.
module sha2_round_step
    import sha2_dual_pkg::*;
(
    input  wstate_t cur,
    input  word_t   wk,
    output wstate_t nxt
);
    word_t t_mix;
    word_t t_top;

    // Compute the two shared temporaries of the round.
    always_comb begin
        t_mix = cur.h + f_bsig1(cur.e) + f_choose(cur.e, cur.f, cur.g) + wk;
        t_top = f_bsig0(cur.a) + f_major(cur.a, cur.b, cur.c);
    end

    // Form the new state: two fresh words, six shifted words.
    always_comb begin
        nxt.a = t_mix + t_top;
        nxt.b = cur.a;
        nxt.c = cur.b;
        nxt.d = cur.c;
        nxt.e = cur.d + t_mix;
        nxt.f = cur.e;
        nxt.g = cur.f;
        nxt.h = cur.g;
    end
endmodule

// File: rtl/sha2_round_chain.sv
`timescale 1ns/1ps
// Module: cascade of NUM_ROUNDS round steps. Round r takes its sum from
// wk_vec[r*WORD_W +: WORD_W]. Assumes a small NUM_ROUNDS, since it sets the logic depth.
module sha2_round_chain
    import sha2_dual_pkg::*;
#(
    parameter int NUM_ROUNDS = ROUNDS
) (
    input  wstate_t                       st_in,
    input  logic [NUM_ROUNDS*WORD_W-1:0]  wk_vec,
    output wstate_t                       st_out
);
    wstate_t stage [NUM_ROUNDS+1];

    assign stage[0] = st_in;

    for (genvar r = 0; r < NUM_ROUNDS; r++) begin : g_round
        sha2_round_step u_step (
            .cur (stage[r]),
            .wk  (wk_vec[r*WORD_W +: WORD_W]),
            .nxt (stage[r+1])
        );
    end

    assign st_out = stage[NUM_ROUNDS];
endmodule

// File: rtl/sha2_dual_round.sv
`timescale 1ns/1ps
// Module: top of the two-round step. Unpacks the two state halves, runs
// two rounds and registers the new A/B/E/F half on start.
// Assumes the caller supplies precomputed message-plus-constant sums.
module sha2_dual_round
    import sha2_dual_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BUS_W-1:0] cdgh_in,
    input  logic [BUS_W-1:0] abef_in,
    input  logic [BUS_W-1:0] wk_in,
    output logic [BUS_W-1:0] abef_out,
    output logic             done
);
    localparam int WK_USED = ROUNDS * WORD_W;

    wstate_t    st_start;
    wstate_t    st_end;
    logic [BUS_W-1:0] abef_next;
    logic       unused_bits;

    // Unpack both halves into the working-state struct by lane position.
    always_comb begin
        st_start.a = abef_in[4*WORD_W-1 -: WORD_W];
        st_start.b = abef_in[3*WORD_W-1 -: WORD_W];
        st_start.e = abef_in[2*WORD_W-1 -: WORD_W];
        st_start.f = abef_in[1*WORD_W-1 -: WORD_W];
        st_start.c = cdgh_in[4*WORD_W-1 -: WORD_W];
        st_start.d = cdgh_in[3*WORD_W-1 -: WORD_W];
        st_start.g = cdgh_in[2*WORD_W-1 -: WORD_W];
        st_start.h = cdgh_in[1*WORD_W-1 -: WORD_W];
    end

    sha2_round_chain #(.NUM_ROUNDS(ROUNDS)) u_chain (
        .st_in  (st_start),
        .wk_vec (wk_in[WK_USED-1:0]),
        .st_out (st_end)
    );

    // Pack the new A/B/E/F half for the output register.
    assign abef_next = {st_end.a, st_end.b, st_end.e, st_end.f};

    // The high sum bits and the final C/D/G/H words are not needed.
    assign unused_bits = ^{wk_in[BUS_W-1:WK_USED], st_end.c, st_end.d, st_end.g, st_end.h};

    // Capture the result on start and raise done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abef_out <= '0;
            done     <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                abef_out <= abef_next;
            end
        end
    end
endmodule

// File: rtl/sha2_dual_round_chk.sv
`timescale 1ns/1ps
// Module: property checker bound to sha2_dual_round. Checks the port
// timing and, through algebraic relations between the inputs and the
// outputs, the content of both rounds.
module sha2_dual_round_chk
    import sha2_dual_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [BUS_W-1:0] cdgh_in,
    input logic [BUS_W-1:0] abef_in,
    input logic [BUS_W-1:0] wk_in,
    input logic [BUS_W-1:0] abef_out,
    input logic             done
);
    word_t o_a, o_b, o_e, o_f;
    word_t unused_wk;

    // Split the output word for readable properties.
    always_comb begin
        o_a = abef_out[127:96];
        o_b = abef_out[95:64];
        o_e = abef_out[63:32];
        o_f = abef_out[31:0];
        unused_wk = wk_in[31:0];
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (abef_out == '0) && !done);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R3
    idle_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(abef_out));

    // R5
    round_one_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (word_t'(o_b - o_f) == word_t'(f_bsig0($past(abef_in[127:96]))
            + f_major($past(abef_in[127:96]), $past(abef_in[95:64]), $past(cdgh_in[127:96]))
            - $past(cdgh_in[95:64]))));

    // R6
    round_two_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (word_t'(o_a - o_e) == word_t'(f_bsig0(o_b)
            + f_major(o_b, $past(abef_in[127:96]), $past(abef_in[95:64]))
            - $past(cdgh_in[127:96]))));
endmodule

bind sha2_dual_round sha2_dual_round_chk u_chk (.*);

// File: tb/sha2_dual_round_test.sv
`timescale 1ns/1ps
module sha2_dual_round_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] cdgh_in = '0;
    logic [127:0] abef_in = '0;
    logic [127:0] wk_in = '0;
    logic [127:0] abef_out;
    logic         done;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] kc [64];
    logic [31:0] wsch [64];

    always #5 clk = ~clk;

    sha2_dual_round uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cdgh_in(cdgh_in),
        .abef_in(abef_in), .wk_in(wk_in), .abef_out(abef_out), .done(done)
    );

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    // Reference: two standard rounds over packed halves (R4..R8).
    function automatic logic [127:0] ref2(input logic [127:0] cdgh, input logic [127:0] abef,
                                          input logic [127:0] wk);
        logic [31:0] a, b, c, d, e, f, g, h, t1, t2, k;
        {a, b, e, f} = abef;
        {c, d, g, h} = cdgh;
        for (int i = 0; i < 2; i++) begin
            k  = wk[i*32 +: 32];
            t1 = h + (rr(e,6) ^ rr(e,11) ^ rr(e,25)) + ((e & f) ^ (~e & g)) + k;
            t2 = (rr(a,2) ^ rr(a,13) ^ rr(a,22)) + ((a & b) ^ (a & c) ^ (b & c));
            h = g; g = f; f = e; e = d + t1;
            d = c; c = b; b = a; a = t1 + t2;
        end
        return {a, b, e, f};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one operation; result and done are sampled one cycle later.
    task automatic run_op(input logic [127:0] cd, input logic [127:0] ab,
                          input logic [127:0] wk, output logic [127:0] res, output logic dn);
        @(negedge clk);
        cdgh_in = cd; abef_in = ab; wk_in = wk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        res = abef_out;
        dn = done;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [127:0] res, res2, ab, cd, wk, nxt;
        logic dn;
        logic [31:0] iv [8];
        logic [31:0] dg [8];
        kc = '{32'h428a2f98,32'h71374491,32'hb5c0fbcf,32'he9b5dba5,32'h3956c25b,32'h59f111f1,32'h923f82a4,32'hab1c5ed5,
               32'hd807aa98,32'h12835b01,32'h243185be,32'h550c7dc3,32'h72be5d74,32'h80deb1fe,32'h9bdc06a7,32'hc19bf174,
               32'he49b69c1,32'hefbe4786,32'h0fc19dc6,32'h240ca1cc,32'h2de92c6f,32'h4a7484aa,32'h5cb0a9dc,32'h76f988da,
               32'h983e5152,32'ha831c66d,32'hb00327c8,32'hbf597fc7,32'hc6e00bf3,32'hd5a79147,32'h06ca6351,32'h14292967,
               32'h27b70a85,32'h2e1b2138,32'h4d2c6dfc,32'h53380d13,32'h650a7354,32'h766a0abb,32'h81c2c92e,32'h92722c85,
               32'ha2bfe8a1,32'ha81a664b,32'hc24b8b70,32'hc76c51a3,32'hd192e819,32'hd6990624,32'hf40e3585,32'h106aa070,
               32'h19a4c116,32'h1e376c08,32'h2748774c,32'h34b0bcb5,32'h391c0cb3,32'h4ed8aa4a,32'h5b9cca4f,32'h682e6ff3,
               32'h748f82ee,32'h78a5636f,32'h84c87814,32'h8cc70208,32'h90befffa,32'ha4506ceb,32'hbef9a3f7,32'hc67178f2};
        iv = '{32'h6a09e667,32'hbb67ae85,32'h3c6ef372,32'ha54ff53a,32'h510e527f,32'h9b05688c,32'h1f83d9ab,32'h5be0cd19};
        dg = '{32'hba7816bf,32'h8f01cfea,32'h414140de,32'h5dae2223,32'hb00361a3,32'h96177a9c,32'hb410ff61,32'hf20015ad};
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 out after reset", abef_out, '0);
        check("R1 done after reset", {127'b0, done}, '0);
        rst_n = 1'b1;

        // R2 R4 R5 R6 R8: directed corners
        run_op('0, '0, '0, res, dn);
        check("R2 done pulse", {127'b0, dn}, 128'd1);
        check("R5 zero state", res, ref2('0, '0, '0));
        run_op({128{1'b1}}, {128{1'b1}}, {128{1'b1}}, res, dn);
        check("R6 all-ones state", res, ref2({128{1'b1}}, {128{1'b1}}, {128{1'b1}}));
        @(negedge clk);
        check("R2 done one cycle", {127'b0, done}, '0);

        // R4 R5 R6 R8: random operands
        for (int n = 0; n < 40; n++) begin
            cd = {$urandom, $urandom, $urandom, $urandom};
            ab = {$urandom, $urandom, $urandom, $urandom};
            wk = {$urandom, $urandom, $urandom, $urandom};
            run_op(cd, ab, wk, res, dn);
            check("R8 random two rounds", res, ref2(cd, ab, wk));
        end

        // R7: high sum bits have no effect
        cd = {$urandom, $urandom, $urandom, $urandom};
        ab = {$urandom, $urandom, $urandom, $urandom};
        wk = {$urandom, $urandom, $urandom, $urandom};
        run_op(cd, ab, wk, res, dn);
        run_op(cd, ab, {~wk[127:64], wk[63:0]}, res2, dn);
        check("R7 upper wk ignored", res2, res);
        run_op(cd, ab, {wk[127:64], wk[31:0], wk[63:32]}, res2, dn);
        check("R7 wk order", res2, ref2(cd, ab, {wk[127:64], wk[31:0], wk[63:32]}));

        // R3: inputs change without start
        @(negedge clk);
        cdgh_in = ~cdgh_in; abef_in = ~abef_in; wk_in = ~wk_in;
        repeat (3) @(negedge clk);
        check("R3 output held", abef_out, res2);
        check("R3 no done", {127'b0, done}, '0);

        // R9: 64 rounds of "abc" by chaining
        for (int t = 0; t < 64; t++) begin
            if (t == 0) wsch[t] = 32'h61626380;
            else if (t < 15) wsch[t] = '0;
            else if (t == 15) wsch[t] = 32'h00000018;
            else wsch[t] = (rr(wsch[t-2],17) ^ rr(wsch[t-2],19) ^ (wsch[t-2] >> 10)) + wsch[t-7]
                         + (rr(wsch[t-15],7) ^ rr(wsch[t-15],18) ^ (wsch[t-15] >> 3)) + wsch[t-16];
        end
        ab = {iv[0], iv[1], iv[4], iv[5]};
        cd = {iv[2], iv[3], iv[6], iv[7]};
        for (int p = 0; p < 32; p++) begin
            wk = {64'h0123456789abcdef, wsch[2*p+1] + kc[2*p+1], wsch[2*p] + kc[2*p]};
            run_op(cd, ab, wk, nxt, dn);
            cd = ab;
            ab = nxt;
        end
        check("R9 abc A", {96'b0, ab[127:96]}, {96'b0, dg[0] - iv[0]});
        check("R9 abc B", {96'b0, ab[95:64]},  {96'b0, dg[1] - iv[1]});
        check("R9 abc E", {96'b0, ab[63:32]},  {96'b0, dg[4] - iv[4]});
        check("R9 abc F", {96'b0, ab[31:0]},   {96'b0, dg[5] - iv[5]});
        check("R9 abc C", {96'b0, cd[127:96]}, {96'b0, dg[2] - iv[2]});
        check("R9 abc D", {96'b0, cd[95:64]},  {96'b0, dg[3] - iv[3]});
        check("R9 abc G", {96'b0, cd[63:32]},  {96'b0, dg[6] - iv[6]});
        check("R9 abc H", {96'b0, cd[31:0]},   {96'b0, dg[7] - iv[7]});

        // R1: reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R1 mid-run reset out", abef_out, '0);
        check("R1 mid-run reset done", {127'b0, done}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule